// File: doc/BRIEF.md
# Bus Ownership and Reset Controller

This block sits between a host and a Z80-family CPU. It lets the host take the CPU's memory bus, give the bus back, and control the CPU reset line. The host issues single-cycle commands. The block drives an active-low CPU reset and an active-low bus request, and it samples the CPU's active-low bus acknowledge. It also produces an output-enable for the address bus and the memory strobes, the idle level the strobes take while that enable is on, and a flag that reports whether the host owns the bus.

Run state and ownership are tracked together as one of four states. Because of this, a run command issued while the host holds a CPU that is in reset becomes a timed reset pulse, and the host keeps the bus afterwards. The reset pulse width comes from a clock-frequency parameter. Any command that has to wait (for an acknowledge, a reset pulse or a bus-request pulse) raises `busy`. While `busy` is high, every command other than init and reset is dropped.

Top module: `bus_owner_ctrl`

## Requirements
- R1: Command codes init (0) and reset (1) are accepted in any state, even while busy. By the following clock edge, `cpu_reset_n` is 0, `busreq_n` is 1, `bus_oe` and `strobe_level` are 0, `busy` is 0 and `state` is RESET. The same outputs hold after the block's own reset.
- R2: `state` encodes RESET=00, RUN=01, RESET_ACQUIRED=10 and RUN_ACQUIRED=11. Bit 1 marks ownership, and `acquired` always equals that bit.
- R3: Request (code 3) in RESET drives `busreq_n` low and `cpu_reset_n` high on the next edge, and raises `busy`. `busack_n` passes through two synchronizer flops. Once the block sees it low, it enables the bus and enters RESET_ACQUIRED with `busy` low.
- R4: Request in RUN asserts `busreq_n`, waits for acknowledge and enters RUN_ACQUIRED with the bus enabled. Request in either acquired state changes nothing.
- R5: Release (code 4) in RESET_ACQUIRED disables the bus, drives `cpu_reset_n` low, sets `busreq_n` high and returns to RESET. In RUN_ACQUIRED it disables the bus, sets `busreq_n` high and returns to RUN. In RESET or RUN it changes nothing.
- R6: Run (code 5) in RESET drives `cpu_reset_n` high and enters RUN. In RESET_ACQUIRED it disables the bus and drives `cpu_reset_n` low for RST_US microseconds of clock cycles. It then re-enables the bus and enters RUN_ACQUIRED.
- R7: Reset-pulse (code 2) in RUN or RUN_ACQUIRED drives `cpu_reset_n` low for exactly RST_US microseconds of clock cycles, and the state does not change. In RESET and RESET_ACQUIRED it is ignored. In the idle RESET state, `cpu_reset_n` is always low.
- R8: When the bus is enabled, `strobe_level` goes high at least one cycle before `bus_oe` rises, and `bus_oe` is never 1 while `strobe_level` is 0. Whenever the bus is disabled, both fall together.
- R9: Bus-request pulse (code 6) disables the bus and holds `busreq_n` high for BRQ_CYCLES cycles, then drives it low. In an acquired state, the block then waits for acknowledge and re-enables the bus. In an unacquired state, it ends idle with `busreq_n` low.
- R10: While `busy` is 1, commands with codes 2 to 6 have no effect. Code 7 is a no-op at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd | input | 3 | Command code |
| busack_n | input | 1 | CPU bus acknowledge, active low, asynchronous |
| cpu_reset_n | output | 1 | CPU reset, active low |
| busreq_n | output | 1 | CPU bus request, active low |
| bus_oe | output | 1 | Output-enable for the address bus and memory strobes |
| strobe_level | output | 1 | Level driven on the memory strobes (1 = inactive high) |
| acquired | output | 1 | Host owns the bus |
| state | output | 2 | Run/ownership state |
| busy | output | 1 | A wait or pulse is in progress |

## Verification
A wrong internal state shows up within one clock edge on `state` and `acquired`. It also shows up on the reset and bus-request levels, because each command's effect on those pins is fixed by the state it was issued in. A lost or early acknowledge shows as `busy` that never clears, or as `bus_oe` rising with `busreq_n` high. Miscounted pulse widths show as a `cpu_reset_n` low time that differs from the parameter by even one cycle. The bench counts that low time exactly.

// File: rtl/bor_pkg.sv
package bor_pkg;

    typedef enum logic [1:0] {
        ST_RESET     = 2'b00,
        ST_RUN       = 2'b01,
        ST_RESET_ACQ = 2'b10,
        ST_RUN_ACQ   = 2'b11
    } own_state_e;

    typedef enum logic [2:0] {
        CMD_INIT     = 3'd0,
        CMD_RESET    = 3'd1,
        CMD_RSTPULSE = 3'd2,
        CMD_REQUEST  = 3'd3,
        CMD_RELEASE  = 3'd4,
        CMD_RUN      = 3'd5,
        CMD_BRQPULSE = 3'd6,
        CMD_NOP      = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACKWAIT,
        PH_RSTLOW,
        PH_BRQHI,
        PH_ARM
    } phase_e;

    localparam int ACQ_BIT = 1;

endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
    parameter int   STAGES   = 2,
    parameter logic INIT_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= INIT_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{INIT_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bor_fsm.sv
module bor_fsm
    import bor_pkg::*;
#(
    parameter int RST_CYCLES = 2500,
    parameter int BRQ_CYCLES = 2,
    parameter int CNT_W      = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid_i,
    input  logic [2:0] cmd_i,
    input  logic       ack_n_i,
    output logic       cpu_reset_n_o,
    output logic       busreq_n_o,
    output logic       oe_o,
    output logic       strobe_o,
    output logic [1:0] state_o,
    output logic       busy_o
);
    typedef struct packed {
        own_state_e       st;
        own_state_e       tgt;
        phase_e           ph;
        logic             rst_n;
        logic             brq_n;
        logic             oe;
        logic             stb;
        logic             rearm;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    localparam regs_t REGS_INIT = '{
        st: ST_RESET, tgt: ST_RESET, ph: PH_IDLE,
        rst_n: 1'b0, brq_n: 1'b1, oe: 1'b0, stb: 1'b0,
        rearm: 1'b0, cnt: '0
    };
    localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYCLES - 1);
    localparam logic [CNT_W-1:0] BRQ_LOAD = CNT_W'(BRQ_CYCLES - 1);

    regs_t r_d, r_q;
    logic  hard_cmd;
    logic  owned_q;

    assign hard_cmd = cmd_valid_i && (cmd_i == CMD_INIT || cmd_i == CMD_RESET);
    assign owned_q  = r_q.st[ACQ_BIT];

    always_comb begin
        r_d = r_q;
        if (hard_cmd) begin
            r_d = REGS_INIT;
        end else begin
            case (r_q.ph)
                PH_IDLE: begin
                    if (cmd_valid_i) begin
                        case (cmd_i)
                            CMD_REQUEST: begin
                                if (!owned_q) begin
                                    r_d.brq_n = 1'b0;
                                    r_d.rst_n = (r_q.st == ST_RESET) ? 1'b1 : r_q.rst_n;
                                    r_d.tgt   = (r_q.st == ST_RESET) ? ST_RESET_ACQ : ST_RUN_ACQ;
                                    r_d.ph    = PH_ACKWAIT;
                                end
                            end
                            CMD_RELEASE: begin
                                if (owned_q) begin
                                    r_d.oe    = 1'b0;
                                    r_d.stb   = 1'b0;
                                    r_d.brq_n = 1'b1;
                                    if (r_q.st == ST_RESET_ACQ) begin
                                        r_d.rst_n = 1'b0;
                                        r_d.st    = ST_RESET;
                                    end else begin
                                        r_d.st    = ST_RUN;
                                    end
                                end
                            end
                            CMD_RUN: begin
                                if (r_q.st == ST_RESET) begin
                                    r_d.rst_n = 1'b1;
                                    r_d.st    = ST_RUN;
                                end else if (r_q.st == ST_RESET_ACQ) begin
                                    r_d.oe    = 1'b0;
                                    r_d.stb   = 1'b0;
                                    r_d.rst_n = 1'b0;
                                    r_d.cnt   = RST_LOAD;
                                    r_d.rearm = 1'b1;
                                    r_d.tgt   = ST_RUN_ACQ;
                                    r_d.ph    = PH_RSTLOW;
                                end
                            end
                            CMD_RSTPULSE: begin
                                if (r_q.st == ST_RUN || r_q.st == ST_RUN_ACQ) begin
                                    r_d.rst_n = 1'b0;
                                    r_d.cnt   = RST_LOAD;
                                    r_d.rearm = 1'b0;
                                    r_d.ph    = PH_RSTLOW;
                                end
                            end
                            CMD_BRQPULSE: begin
                                r_d.oe    = 1'b0;
                                r_d.stb   = 1'b0;
                                r_d.brq_n = 1'b1;
                                r_d.cnt   = BRQ_LOAD;
                                r_d.ph    = PH_BRQHI;
                            end
                            default: ;
                        endcase
                    end
                end
                PH_ACKWAIT: begin
                    if (!ack_n_i) begin
                        r_d.stb = 1'b1;
                        r_d.ph  = PH_ARM;
                    end
                end
                PH_ARM: begin
                    r_d.oe = 1'b1;
                    r_d.st = r_q.tgt;
                    r_d.ph = PH_IDLE;
                end
                PH_RSTLOW: begin
                    if (r_q.cnt == '0) begin
                        r_d.rst_n = 1'b1;
                        if (r_q.rearm) begin
                            r_d.stb   = 1'b1;
                            r_d.rearm = 1'b0;
                            r_d.ph    = PH_ARM;
                        end else begin
                            r_d.ph    = PH_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                PH_BRQHI: begin
                    if (r_q.cnt == '0) begin
                        r_d.brq_n = 1'b0;
                        if (owned_q) begin
                            r_d.tgt = r_q.st;
                            r_d.ph  = PH_ACKWAIT;
                        end else begin
                            r_d.ph  = PH_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                default: r_d = REGS_INIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_INIT;
        else        r_q <= r_d;
    end

    assign cpu_reset_n_o = r_q.rst_n;
    assign busreq_n_o    = r_q.brq_n;
    assign oe_o          = r_q.oe;
    assign strobe_o      = r_q.stb;
    assign state_o       = r_q.st;
    assign busy_o        = (r_q.ph != PH_IDLE);
endmodule

// File: rtl/bus_owner_ctrl.sv
module bus_owner_ctrl #(
    parameter int CLK_HZ      = 250_000_000,
    parameter int RST_US      = 10,
    parameter int BRQ_CYCLES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd,
    input  logic       busack_n,
    output logic       cpu_reset_n,
    output logic       busreq_n,
    output logic       bus_oe,
    output logic       strobe_level,
    output logic       acquired,
    output logic [1:0] state,
    output logic       busy
);
    localparam int RST_CYCLES = (CLK_HZ / 1_000_000) * RST_US;
    localparam int MAX_CNT    = (RST_CYCLES > BRQ_CYCLES) ? RST_CYCLES : BRQ_CYCLES;
    localparam int CNT_W      = $clog2(MAX_CNT + 1);

    logic ack_sync;

    bor_sync #(
        .STAGES   (SYNC_STAGES),
        .INIT_VAL (1'b1)
    ) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (busack_n),
        .q_o   (ack_sync)
    );

    bor_fsm #(
        .RST_CYCLES (RST_CYCLES),
        .BRQ_CYCLES (BRQ_CYCLES),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid_i   (cmd_valid),
        .cmd_i         (cmd),
        .ack_n_i       (ack_sync),
        .cpu_reset_n_o (cpu_reset_n),
        .busreq_n_o    (busreq_n),
        .oe_o          (bus_oe),
        .strobe_o      (strobe_level),
        .state_o       (state),
        .busy_o        (busy)
    );

    assign acquired = state[bor_pkg::ACQ_BIT];
endmodule

// File: rtl/bor_checker.sv
module bor_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd,
    input logic       cpu_reset_n,
    input logic       busreq_n,
    input logic       bus_oe,
    input logic       strobe_level,
    input logic       acquired,
    input logic [1:0] state,
    input logic       busy
);
    // R8: drivers on only with strobes parked high
    assert_oe_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> strobe_level);

    // R8: strobe level leads the enable by at least a cycle
    assert_strobe_leads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(strobe_level));

    // R3: bus enabled only while owned and requested
    assert_oe_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (acquired && !busreq_n));

    // R1: init/reset always lands in RESET
    assert_hard_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd == 3'd0 || cmd == 3'd1)) |=>
        (state == 2'b00 && !cpu_reset_n && busreq_n && !bus_oe && !strobe_level && !busy));

    // R7: idle RESET state keeps the CPU in reset
    assert_reset_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && state == 2'b00) |-> !cpu_reset_n);
endmodule

bind bus_owner_ctrl bor_checker u_bor_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd          (cmd),
    .cpu_reset_n  (cpu_reset_n),
    .busreq_n     (busreq_n),
    .bus_oe       (bus_oe),
    .strobe_level (strobe_level),
    .acquired     (acquired),
    .state        (state),
    .busy         (busy)
);

// File: tb/bus_owner_ctrl_test.sv
`timescale 1ns/1ps
module bus_owner_ctrl_test;
    localparam int RSTW = 2500;  // 250 MHz * 10 us
    localparam int BRQW = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd = 3'd7;
    logic       auto_ack = 1'b1;
    logic       ack_man = 1'b1;
    logic [2:0] dly = 3'b111;
    logic       busack_n;
    logic       cpu_reset_n, busreq_n, bus_oe, strobe_level, acquired, busy;
    logic [1:0] state;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign busack_n = auto_ack ? dly[2] : ack_man;
    always @(negedge clk) dly <= {dly[1:0], busreq_n};

    bus_owner_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .busack_n(busack_n), .cpu_reset_n(cpu_reset_n), .busreq_n(busreq_n),
        .bus_oe(bus_oe), .strobe_level(strobe_level), .acquired(acquired),
        .state(state), .busy(busy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd = 3'd7;
    endtask

    task automatic wait_idle(output bit stb_first);
        stb_first = 0;
        for (int i = 0; i < 20000 && busy; i++) begin
            if (strobe_level && !bus_oe) stb_first = 1;
            @(negedge clk);
        end
    endtask

    task automatic count_rst_low(output int n);
        n = 0;
        while (!cpu_reset_n && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle_port_check(input string req, input int st, input int rn, input int bn, input int oe);
        check(req, "state", state, st);
        check(req, "cpu_reset_n", cpu_reset_n, rn);
        check(req, "busreq_n", busreq_n, bn);
        check(req, "bus_oe", bus_oe, oe);
        check(req, "acquired", acquired, st >> 1);
        check(req, "busy", busy, 0);
    endtask

    task automatic t_reset_state();
        idle_port_check("R1", 0, 0, 1, 0);
        check("R1", "strobe_level", strobe_level, 0);
    endtask

    task automatic t_pulse_ignored_in_reset();
        send(3'd2);
        check("R7", "busy after ignored pulse", busy, 0);
        repeat (5) @(negedge clk);
        idle_port_check("R7", 0, 0, 1, 0);
    endtask

    task automatic t_request_from_reset();
        bit sf;
        send(3'd3);
        check("R3", "busreq_n", busreq_n, 0);
        check("R3", "cpu_reset_n", cpu_reset_n, 1);
        check("R3", "busy", busy, 1);
        check("R3", "bus_oe while waiting", bus_oe, 0);
        wait_idle(sf);
        check("R8", "strobe high before enable", sf, 1);
        idle_port_check("R3", 2, 1, 0, 1);
        check("R2", "acquired bit", acquired, 1);
    endtask

    task automatic t_request_again();
        send(3'd3);
        idle_port_check("R4", 2, 1, 0, 1);
    endtask

    task automatic t_run_from_acq();
        int n;
        bit sf;
        send(3'd5);
        check("R6", "bus_oe off during pulse", bus_oe, 0);
        check("R8", "strobe_level off with bus", strobe_level, 0);
        count_rst_low(n);
        check("R6", "reset low cycles", n, RSTW);
        wait_idle(sf);
        idle_port_check("R6", 3, 1, 0, 1);
    endtask

    task automatic t_release_run_acq();
        send(3'd4);
        idle_port_check("R5", 1, 1, 1, 0);
        check("R8", "strobe_level after release", strobe_level, 0);
        send(3'd4);
        idle_port_check("R5", 1, 1, 1, 0);
    endtask

    task automatic t_pulse_in_run();
        int n;
        send(3'd2);
        check("R7", "busy during pulse", busy, 1);
        count_rst_low(n);
        check("R7", "reset low cycles", n, RSTW);
        idle_port_check("R7", 1, 1, 1, 0);
    endtask

    task automatic t_request_from_run();
        bit sf;
        send(3'd3);
        check("R4", "cpu_reset_n unchanged", cpu_reset_n, 1);
        wait_idle(sf);
        idle_port_check("R4", 3, 1, 0, 1);
    endtask

    task automatic t_brq_pulse_acq();
        int n;
        bit sf;
        send(3'd6);
        check("R9", "bus_oe off", bus_oe, 0);
        n = 0;
        while (busreq_n && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R9", "busreq high cycles", n, BRQW);
        wait_idle(sf);
        idle_port_check("R9", 3, 1, 0, 1);
    endtask

    task automatic t_brq_pulse_unacq();
        send(3'd4);
        send(3'd6);
        check("R9", "busreq_n high", busreq_n, 1);
        repeat (BRQW) @(negedge clk);
        idle_port_check("R9", 1, 1, 0, 0);
    endtask

    task automatic t_reset_cmd_then_run();
        send(3'd1);
        idle_port_check("R1", 0, 0, 1, 0);
        send(3'd5);
        idle_port_check("R6", 1, 1, 1, 0);
    endtask

    task automatic t_busy_ignore();
        auto_ack = 1'b0;
        ack_man = 1'b1;
        send(3'd3);
        check("R10", "busy waiting", busy, 1);
        send(3'd6);
        check("R10", "busreq_n after ignored pulse", busreq_n, 0);
        send(3'd4);
        send(3'd2);
        check("R10", "cpu_reset_n after ignored reset-pulse", cpu_reset_n, 1);
        check("R10", "state", state, 1);
        check("R10", "still busy", busy, 1);
        send(3'd0);
        idle_port_check("R1", 0, 0, 1, 0);
        auto_ack = 1'b1;
    endtask

    task automatic t_release_from_reset_acq();
        bit sf;
        send(3'd3);
        wait_idle(sf);
        idle_port_check("R3", 2, 1, 0, 1);
        send(3'd4);
        idle_port_check("R5", 0, 0, 1, 0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_pulse_ignored_in_reset();
        t_request_from_reset();
        t_request_again();
        t_run_from_acq();
        t_release_run_acq();
        t_pulse_in_run();
        t_request_from_run();
        t_brq_pulse_acq();
        t_brq_pulse_unacq();
        t_reset_cmd_then_run();
        t_busy_ignore();
        t_release_from_reset_acq();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule